// File: doc/BRIEF.md
# Dual Shift-Register Pixel Serializer and Video Mixer

This block turns character-pattern bytes, fetched one per character slot, into a serial pixel stream and merges that stream with sync. It holds two 8-bit shift registers that trade roles under an alternation bit from the timing chain. While one register streams its pixels out, most significant bit first, the other is held still and is refilled from the data bus on the last dot cycle of the slot. On every shift the active register takes a zero into its low end, so it drains to blank once its byte is spent.

The serial bits of the two registers are ORed and then XORed with an inverse-video flag, which gives a single "dark pixel" bit. Horizontal and vertical sync pulses are XORed into one sync bit. A 2-bit level code joins the two for a downstream DAC or for the tape output: sync, dark or light. The dot-cycle count, the alternation bit, the inverse flag and both sync pulses are inputs. One clock edge is one dot.

Top module: `dual_shift_video_mixer`

## Requirements
- R1: A synchronous active-high reset clears both shift registers to zero. After reset, with invert low, `pix_dark` is 0 whichever bank is selected.
- R2: `bank_sel` = 0 makes register A active and register B inactive. `bank_sel` = 1 does the reverse. Only the active register shifts.
- R3: The active register shifts left by one bit on every clock edge. Its most significant bit is the current pixel, so a byte leaves MSB first over 8 clocks.
- R4: On each shift the active register takes a 0 into bit 0. After 8 shifts it yields 0 until it is reloaded.
- R5: The inactive register loads `bus_byte` on a clock edge where `dot_phase` equals 7 (all three bits set). On every other phase it holds its value.
- R6: The active register ignores `dot_phase` = 7 and `bus_byte`, and keeps shifting.
- R7: Only the MSB of the active register reaches the pixel path. The inactive register contributes 0.
- R8: `pix_dark` equals the OR of the two register outputs, XORed with `invert`.
- R9: `sync_on` equals `hsync` XOR `vsync`.
- R10: `level` is 2'b00 when `sync_on` is 1. Otherwise it is 2'b01 when `pix_dark` is 1, and 2'b10 when `pix_dark` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| dot_phase | input | 3 | Dot-cycle count within a character slot |
| bank_sel | input | 1 | Alternation bit; selects the active register |
| bus_byte | input | 8 | Pattern byte from the data bus |
| invert | input | 1 | Inverse-video flag |
| hsync | input | 1 | Horizontal sync pulse, active high |
| vsync | input | 1 | Vertical sync pulse, active high |
| pix_dark | output | 1 | Pixel after inversion; 1 = dark |
| sync_on | output | 1 | Combined sync, active high |
| level | output | 2 | Output level code: 00 sync, 01 dark, 10 light |

## Verification
The effects of a corrupted register show up at the ports at the first dot after the bank toggles. A lost or extra load, a wrong bank, or a shift in the wrong direction gives a wrong pixel on the first dot or within the next seven. A missing zero fill appears on dots 9 and 10 as a repeat of the old byte. Leakage from the inactive register appears during the load slot itself. The sweep runs every byte value through both registers, with the inverse flag and both sync inputs varying dot by dot. Each of these faults therefore meets a pixel that exposes it.

// File: rtl/vmix_pkg.sv
package vmix_pkg;
  typedef enum logic [1:0] {
    LVL_SYNC  = 2'b00,
    LVL_DARK  = 2'b01,
    LVL_LIGHT = 2'b10
  } level_e;

  // Pixel after merging both lanes and applying inverse video
  function automatic logic pixel_dark(input logic lane_a, input logic lane_b,
                                      input logic inv);
    return (lane_a | lane_b) ^ inv;
  endfunction

  // Composite sync from the two pulse inputs
  function automatic logic sync_active(input logic hs, input logic vs);
    return hs ^ vs;
  endfunction

  // Level code: sync dominates, then pixel colour
  function automatic level_e level_of(input logic sync_bit, input logic dark_bit);
    if (sync_bit)      return LVL_SYNC;
    else if (dark_bit) return LVL_DARK;
    else               return LVL_LIGHT;
  endfunction
endpackage

// File: rtl/shift_lane.sv
module shift_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         load_en,
  input  logic [W-1:0] din,
  output logic         bit_out
);
  logic [W-1:0] q;

  // Named events for the assertions
  logic shift_ev, load_ev, hold_ev;
  assign shift_ev = active;
  assign load_ev  = !active && load_en;
  assign hold_ev  = !active && !load_en;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_ev) q <= {q[W-2:0], 1'b0};
    else if (load_ev)  q <= din;
  end

  // Only the active lane presents its MSB
  assign bit_out = active & q[W-1];

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    hold_ev |=> $stable(q));
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> q == $past(din));
  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> q[W-1:1] == $past(q[W-2:0]));
  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> q[0] == 1'b0);
endmodule

// File: rtl/video_merge.sv
module video_merge
  import vmix_pkg::*;
(
  input  logic [1:0] lane_bits,
  input  logic       invert,
  input  logic       hsync,
  input  logic       vsync,
  output logic       dark,
  output logic       sync_bit,
  output logic [1:0] level
);
  always_comb begin
    dark     = pixel_dark(lane_bits[0], lane_bits[1], invert);
    sync_bit = sync_active(hsync, vsync);
    level    = level_of(sync_bit, dark);
  end
endmodule

// File: rtl/dual_shift_video_mixer.sv
module dual_shift_video_mixer #(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] dot_phase,
  input  logic               bank_sel,
  input  logic [DATA_W-1:0]  bus_byte,
  input  logic               invert,
  input  logic               hsync,
  input  logic               vsync,
  output logic               pix_dark,
  output logic               sync_on,
  output logic [1:0]         level
);
  localparam int LANES = 2;
  localparam logic [PHASE_W-1:0] LOAD_PHASE = '1;

  logic             load_slot;
  logic [LANES-1:0] lane_act;
  logic [LANES-1:0] lane_bit;

  assign load_slot = (dot_phase == LOAD_PHASE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_act[i] = (bank_sel == 1'(i));
    shift_lane #(.W(DATA_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .active  (lane_act[i]),
      .load_en (load_slot),
      .din     (bus_byte),
      .bit_out (lane_bit[i])
    );
  end

  video_merge u_merge (
    .lane_bits (lane_bit),
    .invert    (invert),
    .hsync     (hsync),
    .vsync     (vsync),
    .dark      (pix_dark),
    .sync_bit  (sync_on),
    .level     (level)
  );

  // R7: at most one lane feeds the pixel path
  assert_single_source_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_bit));
endmodule

// File: tb/dual_shift_video_mixer_test.sv
`timescale 1ns/1ps
module dual_shift_video_mixer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] dot_phase = 3'd0;
  logic       bank_sel = 1'b0;
  logic [7:0] bus_byte = 8'h00;
  logic       invert = 1'b0;
  logic       hsync = 1'b0;
  logic       vsync = 1'b0;
  logic       pix_dark;
  logic       sync_on;
  logic [1:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_shift_video_mixer uut (
    .clk(clk), .rst(rst), .dot_phase(dot_phase), .bank_sel(bank_sel),
    .bus_byte(bus_byte), .invert(invert), .hsync(hsync), .vsync(vsync),
    .pix_dark(pix_dark), .sync_on(sync_on), .level(level)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected outputs from the pixel bit, inverse flag and sync inputs
  task automatic check_outputs(input string req, input logic pix);
    logic d, s;
    int lv;
    d = pix ^ invert;
    s = hsync ^ vsync;
    lv = s ? 0 : (d ? 1 : 2);
    check({req, "/R8 dark"}, int'(pix_dark), int'(d));
    check("R9 sync", int'(sync_on), int'(s));
    check("R10 level", int'(level), lv);
  endtask

  initial begin
    logic sel;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: both lanes cleared, output blank for either bank
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      bank_sel = c[0];
      #1 check("R1 reset blank", int'(pix_dark), 0);
      check("R1 level", int'(level), 2);
    end
    sel = 1'b0;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] byt;
      byt = 8'(b);
      // R5: load the inactive lane at phase 7
      @(negedge clk);
      bank_sel = sel; dot_phase = 3'd7; bus_byte = byt;
      invert = byt[3]; hsync = 1'b0; vsync = 1'b0;
      #1 check_outputs("R7 inactive gated", 1'b0);
      @(posedge clk);
      // R5: other phases leave the loaded byte alone
      @(negedge clk);
      dot_phase = 3'd5; bus_byte = ~byt; invert = byt[4];
      #1 check_outputs("R7 inactive gated", 1'b0);
      @(posedge clk);
      // R2: toggle bank; the freshly loaded lane streams out
      sel = ~sel;
      for (int k = 0; k < 10; k++) begin
        logic exp_bit;
        @(negedge clk);
        bank_sel = sel;
        dot_phase = (k == 0) ? 3'd7 : 3'(k);   // R6: phase 7 while shifting
        bus_byte = 8'hA5;
        invert = k[0] ^ byt[3];
        hsync = k[1];
        vsync = k[2] ^ byt[2];
        exp_bit = (k < 8) ? byt[7-k] : 1'b0;
        #1;
        if (k == 0)      check_outputs("R2 first pixel", exp_bit);
        else if (k == 1) check_outputs("R6 no load on active", exp_bit);
        else if (k < 8)  check_outputs("R3 msb first", exp_bit);
        else             check_outputs("R4 zero fill", exp_bit);
        @(posedge clk);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule